// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block watches a bank of general-purpose input lines and turns activity on them into a single active-high, level-type interrupt toward the processor. Each line can be set on its own to detect either edges or levels, and its polarity picks rising edge / high level or falling edge / low level. Every detected event is stored in a sticky status register, and this happens whether or not the line is enabled. The enable register then decides which stored events count as pending. The summary interrupt stays high as long as any enabled line is pending.

Software reads and writes a small register set through a simple write strobe, address and data interface, and reads back through a combinational read port. Writing ones to the clear address removes the matching status bits. A combinational helper output reports the index of the lowest-numbered pending line, together with a valid flag, so that a handler can service lines in ascending order. If a line is still pending when the handler finishes, the summary line does not drop. Because of this, an event that arrives during service can never be missed the way it could be with an edge-type summary.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is asserted (synchronous, active low), the status, enable, edge-select and polarity registers are zero, and `irq_out` and `first_valid` are low.
- R2: A line in edge mode (edge-select bit 1) sets its status bit on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. The opposite edge and a steady input set nothing.
- R3: A line in level mode (edge-select bit 0) sets its status bit while its synchronized input equals its polarity bit. The bit stays set after the input leaves that level, until software clears it.
- R4: A status bit latches an event even when the line's enable bit is 0.
- R5: `irq_out` is high exactly when some bit is set in both status and enable. Status bits whose enable bit is 0 do not raise it.
- R6: A write to address 1 (clear) with a 1 in bit k clears status bit k at the next clock edge. Bits written as 0 leave status unchanged.
- R7: If an event for line k is detected in the same cycle that bit k is cleared, the status bit stays set.
- R8: Each input passes through two synchronizing flops, and edges are found against the previous synchronized value. A change driven between clock edges is visible in status after the third rising edge and not after the second.
- R9: `first_valid` is high when any line is pending. `first_idx` then gives the lowest index whose status and enable bits are both 1.
- R10: The register map is: address 0 status (read), address 2 enable, address 3 edge-select, address 4 polarity. The last three read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpio_in | input | N | Asynchronous input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Active-high level summary interrupt |
| first_valid | output | 1 | Some enabled line is pending |
| first_idx | output | $clog2(N) | Lowest pending line index |

## Verification
The bench targets these behaviours:
- **Synchronizer latency.** It samples status after the second and after the third clock edge following an input change. A design with a missing or an extra flop is caught at one of those two points.
- **Level clear race.** It clears a level-mode line while the line is still active. A design that lets the clear win would drop a real event.
- **Sticky level events.** It checks that a level event stays latched after the line returns. A pass-through design would show nothing there.
- **Masking and ordering.** It sets status bits with their enables off, and then with only some enables on. Wrong masking raises the summary too early, and an inverted priority encoder reports the highest pending index instead of the lowest.
- **Clear writes.** Zero-valued clear writes and opposite-polarity edges are shown to change nothing.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register selector encoding for the GPIO interrupt bank.
// Assumes a 3-bit register address on the bank's access port.
package gpio_irq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_CLEAR  = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_EDGE   = 3'd3,
        SEL_POL    = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_irq_sync.sv
// Module: two-stage input synchronizer with a history stage.
// Brings N asynchronous lines into the clock domain and keeps the previous
// synchronized sample so that a later stage can find edges.
// Assumes each line is held for at least two clock cycles.
module gpio_irq_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] hist_q;

    // Purpose: metastability stages plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = hist_q;

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: per-line event detector.
// Combinational: for each line, picks edge or level detection and applies
// the line's polarity. Assumes cur/prev come from the synchronizer.
module gpio_irq_detect #(
    parameter int N = 8
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] edge_sel,
    input  logic [N-1:0] polarity,
    output logic [N-1:0] event_hit
);

    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise_w;
        logic fall_w;
        logic edge_w;
        logic level_w;

        assign rise_w  = cur[g] & ~prev[g];
        assign fall_w  = ~cur[g] & prev[g];
        assign edge_w  = polarity[g] ? rise_w : fall_w;
        assign level_w = (cur[g] == polarity[g]);
        assign event_hit[g] = edge_sel[g] ? edge_w : level_w;
    end

endmodule

// File: rtl/gpio_irq_prio.sv
// Module: lowest-index finder over the pending vector.
// Purely combinational. Assumes N >= 2.
module gpio_irq_prio #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pending,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Purpose: scan from the top so that the lowest set bit is the last one written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// Module: GPIO bank interrupt controller (top).
// Holds the sticky status, enable, edge-select and polarity registers,
// drives the level summary interrupt and the lowest-pending helper.
// Assumes a single clock, synchronous active-low reset, and that software
// accesses registers through a one-cycle write strobe.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      gpio_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      reg_rdata,
    output logic              irq_out,
    output logic              first_valid,
    output logic [IDX_W-1:0]  first_idx
);

    logic [N-1:0] status_q;
    logic [N-1:0] enable_q;
    logic [N-1:0] edge_q;
    logic [N-1:0] pol_q;
    logic [N-1:0] cur_w;
    logic [N-1:0] prev_w;
    logic [N-1:0] event_w;
    logic [N-1:0] clr_w;
    logic [N-1:0] pending_w;

    gpio_irq_sync #(.N(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (gpio_in),
        .cur    (cur_w),
        .prev   (prev_w)
    );

    gpio_irq_detect #(.N(N)) u_detect (
        .cur       (cur_w),
        .prev      (prev_w),
        .edge_sel  (edge_q),
        .polarity  (pol_q),
        .event_hit (event_w)
    );

    // Purpose: decode the write-one-to-clear mask.
    always_comb begin
        clr_w = '0;
        if (reg_wr && (reg_addr == SEL_CLEAR)) begin
            clr_w = reg_wdata;
        end
    end

    // Purpose: configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            edge_q   <= '0;
            pol_q    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                SEL_ENABLE: enable_q <= reg_wdata;
                SEL_EDGE:   edge_q   <= reg_wdata;
                SEL_POL:    pol_q    <= reg_wdata;
                default:    ;
            endcase
        end
    end

    // Purpose: sticky status; a new event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_w) | event_w;
        end
    end

    assign pending_w = status_q & enable_q;
    assign irq_out   = |pending_w;

    gpio_irq_prio #(.N(N)) u_prio (
        .pending (pending_w),
        .found   (first_valid),
        .idx     (first_idx)
    );

    // Purpose: combinational read mux.
    always_comb begin
        case (reg_addr)
            SEL_STATUS: reg_rdata = status_q;
            SEL_ENABLE: reg_rdata = enable_q;
            SEL_EDGE:   reg_rdata = edge_q;
            SEL_POL:    reg_rdata = pol_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Module: assertion checker bound to gpio_irq_bank.
// Observes ports and the status/enable registers; drives nothing.
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [N-1:0]      reg_wdata,
    input logic [N-1:0]      status,
    input logic [N-1:0]      enable,
    input logic              irq_out,
    input logic              first_valid,
    input logic [IDX_W-1:0]  first_idx
);

    logic [N-1:0] keep_mask;
    logic [N-1:0] pend;
    logic [N-1:0] below;

    assign keep_mask = (reg_wr && reg_addr == SEL_CLEAR) ? ~reg_wdata : {N{1'b1}};
    assign pend      = status & enable;
    assign below     = ({{(N-1){1'b0}}, 1'b1} << first_idx) - 1'b1;

    // R3: a set status bit survives unless a clear names it
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & keep_mask)) == $past(status & keep_mask)));

    // R5: summary output agrees with the priority finder's valid flag
    p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == first_valid);

    // R9: reported index is pending and nothing lower is pending
    p_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> (pend[first_idx] && ((pend & below) == '0)));

    // R10: enable register takes the written value
    p_enable_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_ENABLE) |=> (enable == $past(reg_wdata)));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .status      (status_q),
    .enable      (enable_q),
    .irq_out     (irq_out),
    .first_valid (first_valid),
    .first_idx   (first_idx)
);

// File: tb/sim_gpio_irq_bank.sv
// Bench: directed scenarios for gpio_irq_bank, one task each.
module sim_gpio_irq_bank;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     gpio_in = '0;
    logic             reg_wr = 1'b0;
    logic [2:0]       reg_addr = 3'd0;
    logic [N-1:0]     reg_wdata = '0;
    logic [N-1:0]     reg_rdata;
    logic             irq_out;
    logic             first_valid;
    logic [IDX_W-1:0] first_idx;

    int n_run  = 0;
    int n_fail = 0;

    gpio_irq_bank #(.N(N)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .gpio_in     (gpio_in),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_out     (irq_out),
        .first_valid (first_valid),
        .first_idx   (first_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int actual, input int expected);
        n_run++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        rst_n = 1'b0;
        tick(3);
        rd(3'd0, v); check("R1 status", int'(v), 0);
        rd(3'd2, v); check("R1 enable", int'(v), 0);
        rd(3'd3, v); check("R1 edge", int'(v), 0);
        rd(3'd4, v); check("R1 polarity", int'(v), 0);
        check("R1 irq", int'(irq_out), 0);
        check("R1 valid", int'(first_valid), 0);
        rst_n = 1'b1;
        tick(1);
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'hFF);
        tick(3);
        wr(3'd1, 8'hFF);
        rd(3'd0, v); check("R6 clear all", int'(v), 0);
    endtask

    task automatic t_edge_rise();
        logic [N-1:0] v;
        gpio_in[2] = 1'b1;
        tick(2);
        rd(3'd0, v); check("R8 not yet after two edges", int'(v), 0);
        tick(1);
        rd(3'd0, v); check("R2 R8 rising edge latched", int'(v), 32'h04);
        check("R4 latched with enable off, irq low", int'(irq_out), 0);
        wr(3'd1, 8'h04);
        tick(3);
        rd(3'd0, v); check("R2 steady high sets nothing", int'(v), 0);
    endtask

    task automatic t_edge_fall();
        logic [N-1:0] v;
        wr(3'd4, 8'hF7);
        gpio_in[3] = 1'b1;
        tick(4);
        rd(3'd0, v); check("R2 rising ignored on falling line", int'(v), 0);
        gpio_in[3] = 1'b0;
        tick(3);
        rd(3'd0, v); check("R2 falling edge latched", int'(v), 32'h08);
        wr(3'd1, 8'h08);
        rd(3'd0, v); check("R6 cleared bit 3", int'(v), 0);
    endtask

    task automatic t_level();
        logic [N-1:0] v;
        wr(3'd3, 8'hDF);
        tick(2);
        rd(3'd0, v); check("R3 inactive level sets nothing", int'(v), 0);
        gpio_in[5] = 1'b1;
        tick(3);
        rd(3'd0, v); check("R3 level latched", int'(v), 32'h20);
        wr(3'd1, 8'h20);
        rd(3'd0, v); check("R7 set wins over clear", int'(v), 32'h20);
        gpio_in[5] = 1'b0;
        tick(4);
        rd(3'd0, v); check("R3 stays latched after level ends", int'(v), 32'h20);
        wr(3'd1, 8'h20);
        tick(2);
        rd(3'd0, v); check("R6 level cleared after input returns", int'(v), 0);
    endtask

    task automatic t_mask();
        logic [N-1:0] v;
        gpio_in[1] = 1'b1;
        gpio_in[6] = 1'b1;
        tick(3);
        rd(3'd0, v); check("R4 two lines latched", int'(v), 32'h42);
        check("R5 no irq with enables off", int'(irq_out), 0);
        check("R9 no valid with enables off", int'(first_valid), 0);
        wr(3'd2, 8'h40);
        check("R5 irq with one enable", int'(irq_out), 1);
        check("R9 index 6", int'(first_idx), 6);
        wr(3'd2, 8'h42);
        check("R9 lowest index 1", int'(first_idx), 1);
        wr(3'd1, 8'h00);
        rd(3'd0, v); check("R6 zero write no effect", int'(v), 32'h42);
        wr(3'd1, 8'h02);
        check("R9 index 6 after clear", int'(first_idx), 6);
        check("R5 irq still high", int'(irq_out), 1);
        wr(3'd1, 8'h40);
        check("R5 irq low when none pending", int'(irq_out), 0);
        check("R9 valid low", int'(first_valid), 0);
    endtask

    task automatic t_readback();
        logic [N-1:0] v;
        wr(3'd2, 8'hA5);
        rd(3'd2, v); check("R10 enable readback", int'(v), 32'hA5);
        rd(3'd3, v); check("R10 edge readback", int'(v), 32'hDF);
        rd(3'd4, v); check("R10 polarity readback", int'(v), 32'hF7);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_edge_rise();
        t_edge_fall();
        t_level();
        t_mask();
        t_readback();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule